// File: doc/BRIEF.md
# Table-Driven Multicycle Sequencer

This block sequences a small multicycle load/store processor. A 4-bit state register and a lookup table together decide, every clock, which of sixteen datapath control lines are active and which step follows. The table is addressed by the current state joined with the 6-bit instruction opcode. Each table word carries the sixteen control lines in its upper part and the following state in its lower four bits. This means one lookup yields both the outputs and the next step.

The control lines depend on the state alone, so that part of a word repeats for every opcode. Only the next-state part changes with the opcode, and it does so in the decode and address steps. Ten state codes are used. Any other code, and any opcode the sequencer does not recognise at a dispatch point, sends the machine back to the fetch step. The opcode and the control lines are plain level signals with no handshake. The datapath samples the control lines during the cycle in which they are shown.

Top module: `mcu_ctl_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the state becomes fetch (code 0) whatever the opcode. After that edge `ctrl_o` shows the fetch word 0x9408.
- R2: From fetch, the next edge always moves to decode (code 1), whatever the opcode.
- R3: From decode, the opcode selects the next state. Load 100011 and store 101011 go to address (2). Register-type 000000 goes to execute (6). Branch-equal 000100 goes to branch (8). Jump 000010 goes to jump (9).
- R4: From address (2), load goes to memory read (3) and store goes to memory write (5).
- R5: The load path continues 3 → 4 → 0. The store path continues 5 → 0.
- R6: Execute (6) goes to register write-back (7) and then to 0. Branch (8) and jump (9) return to 0 after one cycle.
- R7: `ctrl_o` depends only on the state. A change of `opcode_i` inside a cycle leaves `ctrl_o` unchanged.
- R8: An opcode not listed in R3 sends the machine to fetch when it is seen in decode. An opcode that is neither load nor store does the same when it is seen in address.
- R9: `ctrl_o` bit layout:
  - 15 PC write
  - 14 conditional PC write
  - 13 data-address select
  - 12 memory read
  - 11 memory write
  - 10 instruction-register write
  - 9 write-back-from-memory
  - 8:7 PC source
  - 6:5 ALU mode
  - 4:3 ALU B select
  - 2 ALU A select
  - 1 register write
  - 0 destination select
- R10: Words by state: fetch 0x9408, decode 0x0018, address 0x0014, memory read 0x3000, load write-back 0x0202, memory write 0x2800, execute 0x0044, R write-back 0x0003, branch 0x40A4, jump 0x8100. Unused codes give 0x0000.
- R11: In every state except decode and address, the next state does not depend on the opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high, forces fetch |
| opcode_i | input | 6 | Opcode field of the current instruction |
| ctrl_o | output | 16 | Datapath control lines, layout per R9 |

## Verification
The control word is due one rising edge after the opcode or reset level that chose the step. There is one register on the path, and the lookup after it is combinational. The driver changes inputs on the falling edge and queues the word expected after the next rising edge. The monitor compares 1 ns after that rising edge. The opcode-independence check of R7 changes the opcode between those two points and compares within the same cycle, when no edge can have moved the state.

// File: rtl/mcu_ctl_pkg.sv
package mcu_ctl_pkg;

  localparam int ST_W   = 4;
  localparam int OP_W   = 6;
  localparam int CTRL_W = 16;
  localparam int WORD_W = CTRL_W + ST_W;
  localparam int ADDR_W = ST_W + OP_W;

  // state codes
  localparam logic [ST_W-1:0] S_FETCH  = 4'd0;
  localparam logic [ST_W-1:0] S_DECODE = 4'd1;
  localparam logic [ST_W-1:0] S_ADDR   = 4'd2;
  localparam logic [ST_W-1:0] S_MRD    = 4'd3;
  localparam logic [ST_W-1:0] S_LDWB   = 4'd4;
  localparam logic [ST_W-1:0] S_MWR    = 4'd5;
  localparam logic [ST_W-1:0] S_EXEC   = 4'd6;
  localparam logic [ST_W-1:0] S_RWB    = 4'd7;
  localparam logic [ST_W-1:0] S_BRANCH = 4'd8;
  localparam logic [ST_W-1:0] S_JUMP   = 4'd9;

  // opcodes
  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OP_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_JMP   = 6'b000010;

  // control bit positions
  localparam int B_PC_WR   = 15;
  localparam int B_PC_COND = 14;
  localparam int B_DADDR   = 13;
  localparam int B_MEM_RD  = 12;
  localparam int B_MEM_WR  = 11;
  localparam int B_IR_WR   = 10;
  localparam int B_WB_MEM  = 9;
  localparam int B_PC_SRC  = 7;  // 2 bits
  localparam int B_ALU_MD  = 5;  // 2 bits
  localparam int B_ALU_B   = 3;  // 2 bits
  localparam int B_ALU_A   = 2;
  localparam int B_RF_WR   = 1;
  localparam int B_RF_DST  = 0;

  function automatic logic [CTRL_W-1:0] ctrl_of(input logic [ST_W-1:0] st);
    logic [CTRL_W-1:0] c;
    c = '0;
    case (st)
      S_FETCH: begin
        c[B_PC_WR] = 1'b1; c[B_MEM_RD] = 1'b1; c[B_IR_WR] = 1'b1;
        c[B_ALU_B +: 2] = 2'b01;
      end
      S_DECODE: c[B_ALU_B +: 2] = 2'b11;
      S_ADDR: begin
        c[B_ALU_A] = 1'b1; c[B_ALU_B +: 2] = 2'b10;
      end
      S_MRD: begin
        c[B_DADDR] = 1'b1; c[B_MEM_RD] = 1'b1;
      end
      S_LDWB: begin
        c[B_RF_WR] = 1'b1; c[B_WB_MEM] = 1'b1;
      end
      S_MWR: begin
        c[B_DADDR] = 1'b1; c[B_MEM_WR] = 1'b1;
      end
      S_EXEC: begin
        c[B_ALU_A] = 1'b1; c[B_ALU_MD +: 2] = 2'b10;
      end
      S_RWB: begin
        c[B_RF_WR] = 1'b1; c[B_RF_DST] = 1'b1;
      end
      S_BRANCH: begin
        c[B_PC_COND] = 1'b1; c[B_PC_SRC +: 2] = 2'b01;
        c[B_ALU_MD +: 2] = 2'b01; c[B_ALU_A] = 1'b1;
      end
      S_JUMP: begin
        c[B_PC_WR] = 1'b1; c[B_PC_SRC +: 2] = 2'b10;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

  function automatic logic [ST_W-1:0] next_of(input logic [ST_W-1:0] st,
                                               input logic [OP_W-1:0] op);
    logic [ST_W-1:0] n;
    n = S_FETCH;
    case (st)
      S_FETCH: n = S_DECODE;
      S_DECODE: begin
        if (op == OP_LOAD || op == OP_STORE) n = S_ADDR;
        else if (op == OP_RTYPE)             n = S_EXEC;
        else if (op == OP_BEQ)               n = S_BRANCH;
        else if (op == OP_JMP)               n = S_JUMP;
        else                                 n = S_FETCH;
      end
      S_ADDR: begin
        if (op == OP_LOAD)       n = S_MRD;
        else if (op == OP_STORE) n = S_MWR;
        else                     n = S_FETCH;
      end
      S_MRD:   n = S_LDWB;
      S_MWR:   n = S_FETCH;
      S_EXEC:  n = S_RWB;
      default: n = S_FETCH;
    endcase
    return n;
  endfunction

  function automatic logic [WORD_W-1:0] rom_entry(input logic [ADDR_W-1:0] a);
    return {ctrl_of(a[ADDR_W-1 -: ST_W]), next_of(a[ADDR_W-1 -: ST_W], a[OP_W-1:0])};
  endfunction

endpackage

// File: rtl/mcu_ctl_rom.sv
module mcu_ctl_rom
  import mcu_ctl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = WORD_W
) (
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] word_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] table_w [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    assign table_w[a] = DW'(rom_entry(ADDR_W'(a)));
  end

  assign word_o = table_w[addr_i];
endmodule

// File: rtl/mcu_state_reg.sv
module mcu_state_reg
  import mcu_ctl_pkg::*;
#(
  parameter int W = ST_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] next_i,
  output logic [W-1:0] state_o
);
  always_ff @(posedge clk) begin
    if (rst) state_o <= W'(S_FETCH);
    else     state_o <= next_i;
  end
endmodule

// File: rtl/mcu_ctl_unit.sv
module mcu_ctl_unit
  import mcu_ctl_pkg::*;
#(
  parameter int SW = ST_W,
  parameter int OW = OP_W,
  parameter int CW = CTRL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [OW-1:0] opcode_i,
  output logic [CW-1:0] ctrl_o
);
  localparam int AW = SW + OW;
  localparam int DW = CW + SW;

  logic [SW-1:0] state_q;
  logic [SW-1:0] state_d;
  logic [DW-1:0] word;

  mcu_ctl_rom #(.AW(AW), .DW(DW)) u_rom (
    .addr_i ({state_q, opcode_i}),
    .word_o (word)
  );

  assign ctrl_o  = word[DW-1 -: CW];
  assign state_d = word[SW-1:0];

  mcu_state_reg #(.W(SW)) u_state (
    .clk     (clk),
    .rst     (rst),
    .next_i  (state_d),
    .state_o (state_q)
  );
endmodule

// File: rtl/mcu_ctl_unit_chk.sv
module mcu_ctl_unit_chk
  import mcu_ctl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   opcode_i,
  input logic [ST_W-1:0]   state_q,
  input logic [CTRL_W-1:0] ctrl_o
);
  assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state_q == S_FETCH && ctrl_o == 16'h9408));

  assert_fetch_decode_R2: assert property (@(posedge clk) disable iff (rst)
    state_q == S_FETCH |=> state_q == S_DECODE);

  assert_decode_load_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DECODE && opcode_i == OP_LOAD) |=> state_q == S_ADDR);

  assert_addr_store_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_ADDR && opcode_i == OP_STORE) |=> state_q == S_MWR);

  assert_store_done_R5: assert property (@(posedge clk) disable iff (rst)
    state_q == S_MWR |=> state_q == S_FETCH);

  assert_rwb_done_R6: assert property (@(posedge clk) disable iff (rst)
    state_q == S_RWB |=> state_q == S_FETCH);

  assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (rst)
    $stable(state_q) |-> $stable(ctrl_o));

  assert_used_codes_R8: assert property (@(posedge clk) disable iff (rst)
    state_q <= S_JUMP);

  assert_mrd_word_R10: assert property (@(posedge clk) disable iff (rst)
    state_q == S_MRD |-> ctrl_o == 16'h3000);
endmodule

bind mcu_ctl_unit mcu_ctl_unit_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .opcode_i (opcode_i),
  .state_q  (state_q),
  .ctrl_o   (ctrl_o)
);

// File: tb/mcu_ctl_unit_tb_top.sv
`timescale 1ns/1ps
module mcu_ctl_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = 6'd0;
  logic [15:0] ctrl;

  localparam logic [5:0] RT = 6'b000000, LD = 6'b100011, ST = 6'b101011,
                         BQ = 6'b000100, JP = 6'b000010, BAD = 6'b111111;
  localparam logic [15:0] W_F = 16'h9408, W_D = 16'h0018, W_A = 16'h0014,
                          W_MR = 16'h3000, W_LW = 16'h0202, W_MW = 16'h2800,
                          W_EX = 16'h0044, W_RW = 16'h0003, W_BR = 16'h40A4,
                          W_JP = 16'h8100;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  mcu_ctl_unit dut_i (.clk(clk), .rst(rst), .opcode_i(opcode), .ctrl_o(ctrl));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic [5:0] op,
                      input logic [15:0] exp, input string tag);
    @(negedge clk);
    rst = r;
    opcode = op;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // monitor: one result due per edge, sampled 1 ns after it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, ctrl, e);
      end
    end
  end

  initial begin
    step(1, LD, W_F, "R1 reset");
    step(1, JP, W_F, "R1 reset ignores opcode");
    // load path
    step(0, BAD, W_D, "R2 fetch->decode any op");
    step(0, LD, W_A, "R3 load->address");
    // R7: opcode wiggle within address state
    @(posedge clk); #1.5;
    opcode = JP; #0.2; check("R7 ctrl stable on opcode change", ctrl, W_A);
    opcode = RT; #0.2; check("R7 ctrl stable on opcode change", ctrl, W_A);
    step(0, LD, W_MR, "R4 load->mem read");
    step(0, RT, W_LW, "R5 mem read->write-back, R11 op ignored");
    step(0, BAD, W_F, "R5 write-back->fetch, R11");
    // store path
    step(0, RT, W_D, "R2");
    step(0, ST, W_A, "R3 store->address");
    step(0, ST, W_MW, "R4 store->mem write");
    step(0, LD, W_F, "R5 mem write->fetch, R11");
    // register type
    step(0, JP, W_D, "R2");
    step(0, RT, W_EX, "R3 rtype->execute");
    step(0, LD, W_RW, "R6 execute->write-back, R11");
    step(0, ST, W_F, "R6 write-back->fetch");
    // branch
    step(0, BQ, W_D, "R2");
    step(0, BQ, W_BR, "R3 branch");
    step(0, LD, W_F, "R6 branch->fetch, R11");
    // jump
    step(0, JP, W_D, "R2");
    step(0, JP, W_JP, "R3 jump");
    step(0, JP, W_F, "R6 jump->fetch");
    // unmatched opcodes
    step(0, LD, W_D, "R2");
    step(0, BAD, W_F, "R8 unknown in decode->fetch");
    step(0, LD, W_D, "R2");
    step(0, LD, W_A, "R3");
    step(0, RT, W_F, "R8 non load/store in address->fetch");
    // reset in flight
    step(0, ST, W_D, "R2");
    step(0, ST, W_A, "R3");
    step(1, ST, W_F, "R1 reset mid path");
    step(0, ST, W_D, "R9 R10 decode word after reset");
    @(negedge clk);
    opcode = BAD;
    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule